// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device side of a three-wire serial memory. It has a chip select, a serial clock and a serial data input, and it drives a data output with a separate output-enable. All three inputs are resynchronised into one system clock domain. The block samples serial data on each detected rising edge of the serial clock, ignores zeros that come before a start bit, and then collects a two-bit opcode and an address. It then runs the command against an internal word array built from registers. Words are 16 bits wide, or 8 bits when the organisation parameter selects byte mode. In byte mode the address grows by one bit.

Four commands change the array: single-word write, single-word erase, fill-all and wipe-all. Each is accepted only while the write latch is open. An accepted command starts a busy timer whose length is set in system clock cycles. While chip select is high, the data output shows the ready/busy flag until the next start bit arrives. Reads put out a leading zero and then the addressed word, most significant bit first. If clocking continues, the block streams the following words without a gap and wraps past the top address.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A rising serial-clock edge samples data-in. Zeros sampled while idle are skipped. The first 1 is the start bit, and it is followed by a 2-bit opcode sent MSB first: 10 read, 01 write, 11 erase, 00 extended. After the opcode come the address bits, MSB first.
- R2: After the last address bit of a read, data-out is enabled and shows 0. Each following rising edge shifts out the next bit of the addressed word, starting with the MSB.
- R3: While chip select stays high, the bit after the last bit of a word is the MSB of the word at address+1, with no dummy bit. The address wraps from the top word to word 0.
- R4: A write followed by one word of data, MSB first, stores that word at the given address. The array resets to all ones.
- R5: An erase sets the addressed word to all ones. The extended code 10 (the top two address bits) sets every word to all ones.
- R6: The extended code 01, followed by one data word, stores that word in every location whatever the previous contents.
- R7: The write latch is closed at reset and by extended code 00, and opened by extended code 11. While it is closed, the four modifying commands leave the array unchanged and show ready (1) at once, with no busy phase.
- R8: An accepted modifying command holds data-out at 0 for T_WORD (write, erase), T_ERAL (wipe-all) or T_WRAL (fill-all) clock cycles, plus a fixed latency of a few cycles. Data-out then shows 1. The flag stays on data-out through later clock edges with data-in 0, until a start bit is sampled, which disables the output.
- R9: From the edge that commits a modifying command until the busy time ends, serial clock and data-in have no effect. A start bit sent during this time is not seen.
- R10: While chip select is low, the data-out enable is 0. Lowering chip select in the middle of a frame drops the frame and changes nothing.
- R11: For the extended commands, only the top two address bits matter. The remaining address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the inputs are sampled with it and the busy timer runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (read data or ready/busy flag) |
| sdo_en_o | output | 1 | Output enable for sdo_o; 0 means high impedance |

## Verification
The hardest case to reach is the busy window. Inputs must be ignored there, and the ready flag must then survive further clocking. Nothing about either shows directly at the ports. The bench starts an erase and, while the timer runs, clocks in a start bit followed by opcode bits. After the timer expires it checks three things: the output shows the ready flag rather than a high-impedance command phase, the flag survives one more clock with data-in low, and a real start bit then turns the output off. Aborted frames and commands sent while the latch is closed are checked by reading the array back.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_BUSY,
    ST_STAT
  } mw_state_e;

  // opcode values carried on the wire
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  // extended command selected by the top two address bits
  typedef enum logic [1:0] {
    XT_LOCK   = 2'b00,
    XT_FILL   = 2'b01,
    XT_WIPE   = 2'b10,
    XT_UNLOCK = 2'b11
  } mw_ext_e;

  typedef enum logic [1:0] {
    PRG_WORD,
    PRG_WIPE,
    PRG_FILL
  } prg_kind_e;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = pipe_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= '0;
      else        pipe_q[g] <= src;
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer
  import mw_pkg::*;
#(
  parameter int T_WORD = 1000,
  parameter int T_ERAL = 2000,
  parameter int T_WRAL = 4000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  prg_kind_e kind,
  output logic      busy
);

  localparam int TMAX = (T_WRAL > T_ERAL) ? ((T_WRAL > T_WORD) ? T_WRAL : T_WORD)
                                          : ((T_ERAL > T_WORD) ? T_ERAL : T_WORD);
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] cnt_q, cnt_d, len;

  always_comb begin
    unique case (kind)
      PRG_WIPE: len = TW'(T_ERAL);
      PRG_FILL: len = TW'(T_WRAL);
      default:  len = TW'(T_WORD);
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = len;
    else if (cnt_q != '0)   cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int AW = 4,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          we_all,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (we_all || (waddr == AW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '1;
      else if (hit) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int AW = 4,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rise,
  input  logic          di,
  input  logic          busy,
  input  logic [WW-1:0] rdata,
  output mw_state_e     st_o,
  output logic          dout_o,
  output logic [AW-1:0] raddr,
  output logic          arr_we,
  output logic          arr_all,
  output logic [AW-1:0] arr_addr,
  output logic [WW-1:0] arr_data,
  output logic          prg_start,
  output prg_kind_e     prg_kind
);

  localparam int NMAX = (AW > WW) ? AW : WW;
  localparam int CW   = $clog2(NMAX);

  mw_state_e      st_q, st_d;
  mw_op_e         op_q, op_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [NMAX-1:0] sr_q, sr_d, sr_nx;
  logic [AW-1:0]  addr_q, addr_d, a_nx;
  logic [WW-1:0]  rw_q, rw_d;
  logic           dout_q, dout_d;
  logic           wen_q, wen_d;
  logic           commit, c_all, c_ones;
  prg_kind_e      c_kind;
  mw_ext_e        ext;

  assign sr_nx = {sr_q[NMAX-2:0], di};
  assign a_nx  = sr_nx[AW-1:0];
  assign ext   = mw_ext_e'(sr_nx[AW-1 -: 2]);

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    addr_d = addr_q;
    rw_d   = rw_q;
    dout_d = dout_q;
    wen_d  = wen_q;
    commit = 1'b0;
    c_all  = 1'b0;
    c_ones = 1'b0;
    c_kind = PRG_WORD;
    if (st_q == ST_BUSY) begin
      if (!busy) st_d = cs ? ST_STAT : ST_IDLE;
    end else if (!cs) begin
      st_d = ST_IDLE;
    end else if (rise) begin
      unique case (st_q)
        ST_IDLE, ST_STAT: begin
          if (di) begin
            st_d  = ST_OPC;
            cnt_d = '0;
          end
        end
        ST_OPC: begin
          op_d = mw_op_e'({op_q[0], di});
          if (cnt_q == '0) begin
            cnt_d = CW'(1);
          end else begin
            cnt_d = '0;
            st_d  = ST_ADDR;
          end
        end
        ST_ADDR: begin
          sr_d = sr_nx;
          if (cnt_q != CW'(AW - 1)) begin
            cnt_d = cnt_q + CW'(1);
          end else begin
            cnt_d  = '0;
            addr_d = a_nx;
            unique case (op_q)
              OP_READ: begin
                st_d   = ST_READ;
                rw_d   = rdata;
                dout_d = 1'b0;
              end
              OP_WRITE: st_d = ST_DATA;
              OP_ERASE: begin
                commit = 1'b1;
                c_ones = 1'b1;
              end
              default: begin
                unique case (ext)
                  XT_UNLOCK: begin
                    wen_d = 1'b1;
                    st_d  = ST_IDLE;
                  end
                  XT_LOCK: begin
                    wen_d = 1'b0;
                    st_d  = ST_IDLE;
                  end
                  XT_FILL: st_d = ST_DATA;
                  default: begin
                    commit = 1'b1;
                    c_all  = 1'b1;
                    c_ones = 1'b1;
                    c_kind = PRG_WIPE;
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          sr_d = sr_nx;
          if (cnt_q != CW'(WW - 1)) begin
            cnt_d = cnt_q + CW'(1);
          end else begin
            cnt_d  = '0;
            commit = 1'b1;
            c_all  = (op_q == OP_EXT);
            c_kind = (op_q == OP_EXT) ? PRG_FILL : PRG_WORD;
          end
        end
        ST_READ: begin
          dout_d = rw_q[WW-1];
          if (cnt_q == CW'(WW - 1)) begin
            cnt_d  = '0;
            addr_d = addr_q + AW'(1);
            rw_d   = rdata;
          end else begin
            cnt_d = cnt_q + CW'(1);
            rw_d  = {rw_q[WW-2:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
    if (commit) st_d = wen_q ? ST_BUSY : ST_STAT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_EXT;
      cnt_q  <= '0;
      sr_q   <= '0;
      addr_q <= '0;
      rw_q   <= '0;
      dout_q <= 1'b0;
      wen_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      addr_q <= addr_d;
      rw_q   <= rw_d;
      dout_q <= dout_d;
      wen_q  <= wen_d;
    end
  end

  assign st_o      = st_q;
  assign dout_o    = dout_q;
  assign raddr     = (st_q == ST_READ) ? (addr_q + AW'(1)) : a_nx;
  assign arr_we    = commit && wen_q;
  assign arr_all   = c_all;
  assign arr_addr  = (st_q == ST_DATA) ? addr_q : a_nx;
  assign arr_data  = c_ones ? '1 : sr_nx[WW-1:0];
  assign prg_start = commit && wen_q;
  assign prg_kind  = c_kind;

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter bit ORG_X16     = 1'b1,
  parameter int CORE_AW     = 4,
  parameter int T_WORD      = 1000,
  parameter int T_ERAL      = 2000,
  parameter int T_WRAL      = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  output logic sdo_o,
  output logic sdo_en_o
);

  localparam int WW = ORG_X16 ? 16 : 8;
  localparam int AW = ORG_X16 ? CORE_AW : CORE_AW + 1;

  logic          cs_s, sclk_s, di_s, sclk_d, rise;
  logic          prg_busy, prg_start, arr_we, arr_all, dout, in_read;
  prg_kind_e     prg_kind;
  mw_state_e     st;
  logic [AW-1:0] raddr, arr_addr;
  logic [WW-1:0] rdata, arr_data;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_i, sclk_i, di_i}),
    .q     ({cs_s, sclk_s, di_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise = sclk_s && !sclk_d;

  mw_ctrl #(.AW(AW), .WW(WW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs_s),
    .rise      (rise),
    .di        (di_s),
    .busy      (prg_busy),
    .rdata     (rdata),
    .st_o      (st),
    .dout_o    (dout),
    .raddr     (raddr),
    .arr_we    (arr_we),
    .arr_all   (arr_all),
    .arr_addr  (arr_addr),
    .arr_data  (arr_data),
    .prg_start (prg_start),
    .prg_kind  (prg_kind)
  );

  mw_array #(.AW(AW), .WW(WW)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (arr_we),
    .we_all (arr_all),
    .waddr  (arr_addr),
    .wdata  (arr_data),
    .raddr  (raddr),
    .rdata  (rdata)
  );

  mw_busy_timer #(.T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prg_start),
    .kind  (prg_kind),
    .busy  (prg_busy)
  );

  assign in_read  = (st == ST_READ);
  assign sdo_en_o = cs_s && (st == ST_READ || st == ST_BUSY || st == ST_STAT);
  assign sdo_o    = in_read ? dout : (st == ST_STAT);

endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk #(
  parameter int STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_i,
  input logic sdo_o,
  input logic sdo_en_o,
  input logic busy,
  input logic arr_we,
  input logic in_read
);

  // R10
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_i, STAGES) |-> !sdo_en_o);

  // R8
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sdo_en_o) |-> !sdo_o);

  // R8
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> busy);

  // R9
  busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arr_we);

  // R2
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_read) |-> !sdo_o);

endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk #(.STAGES(SYNC_STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_i     (cs_i),
  .sdo_o    (sdo_o),
  .sdo_en_o (sdo_en_o),
  .busy     (prg_busy),
  .arr_we   (arr_we),
  .in_read  (in_read)
);

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;

  localparam int CORE_AW = 3;
  localparam int AW      = 3;
  localparam int WW      = 16;
  localparam int DEPTH   = 8;
  localparam int TWD     = 60;
  localparam int TER     = 90;
  localparam int TWA     = 120;
  localparam int H       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic sdo, sdo_en;
  int   n_chk = 0, n_bad = 0;
  bit   wen_m = 1'b0;
  logic [WW-1:0] mdl [DEPTH];

  always #4 clk = ~clk;

  mw_eeprom_slave #(.ORG_X16(1'b1), .CORE_AW(CORE_AW), .T_WORD(TWD), .T_ERAL(TER),
                    .T_WRAL(TWA), .SYNC_STAGES(2)) i_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .sdo_o(sdo), .sdo_en_o(sdo_en));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // drive one serial bit; return {en,do} seen just before its rising edge
  task automatic bit_io(input logic b, output logic [1:0] s);
    di = b;
    repeat (H) @(negedge clk);
    s = {sdo_en, sdo};
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic tick(input logic b);
    logic [1:0] s;
    bit_io(b, s);
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic cs_off();
    cs = 1'b0;
    sclk = 1'b0;
    di = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a);
    tick(1'b1);
    tick(op[1]);
    tick(op[0]);
    for (int i = AW - 1; i >= 0; i--) tick(a[i]);
  endtask

  task automatic send_data(input logic [WW-1:0] d);
    for (int i = WW - 1; i >= 0; i--) tick(d[i]);
  endtask

  // after the committing edge: busy then ready, or ready at once when locked
  task automatic finish_prog(input int t, input string tag);
    int n;
    if (!wen_m) begin
      check({sdo_en, sdo} == 2'b11, {tag, " R7 locked: ready at once"}, {sdo_en, sdo}, 2'b11);
      return;
    end
    check({sdo_en, sdo} == 2'b10, {tag, " R8 busy shown"}, {sdo_en, sdo}, 2'b10);
    n = H;
    while (!(sdo_en && sdo) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n >= t + 2 && n <= t + 6, {tag, " R8 busy length"}, n, t + 4);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [WW-1:0] d, input int lead);
    cs_on();
    repeat (lead) tick(1'b0);
    send_cmd(2'b01, a);
    send_data(d);
    finish_prog(TWD, "write");
    cs_off();
    if (wen_m) mdl[a] = d;
  endtask

  task automatic do_erase(input logic [AW-1:0] a);
    cs_on();
    send_cmd(2'b11, a);
    finish_prog(TWD, "erase");
    cs_off();
    if (wen_m) mdl[a] = '1;
  endtask

  task automatic do_ext(input logic [1:0] code, input logic x);
    cs_on();
    send_cmd(2'b00, {code, x});
    cs_off();
    if (code == 2'b11) wen_m = 1'b1;
    if (code == 2'b00) wen_m = 1'b0;
  endtask

  task automatic do_wral(input logic [WW-1:0] d, input logic x);
    cs_on();
    send_cmd(2'b00, {2'b01, x});
    send_data(d);
    finish_prog(TWA, "fill-all");
    cs_off();
    if (wen_m) for (int i = 0; i < DEPTH; i++) mdl[i] = d;
  endtask

  task automatic do_eral(input logic x);
    cs_on();
    send_cmd(2'b00, {2'b10, x});
    finish_prog(TER, "wipe-all");
    cs_off();
    if (wen_m) for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
  endtask

  task automatic read_seq(input logic [AW-1:0] a, input int nw, input string tag);
    logic [1:0] s;
    logic [WW-1:0] w, exp;
    bit en_ok;
    cs_on();
    send_cmd(2'b10, a);
    bit_io(1'b0, s);
    check(s == 2'b10, {tag, " R2 dummy zero"}, s, 2'b10);
    for (int k = 0; k < nw; k++) begin
      en_ok = 1'b1;
      for (int b = 0; b < WW; b++) begin
        bit_io(1'b0, s);
        w = {w[WW-2:0], s[0]};
        en_ok &= s[1];
      end
      exp = mdl[(int'(a) + k) % DEPTH];
      if (k == 0) check(en_ok && w == exp, {tag, " R2 word"}, w, exp);
      else        check(en_ok && w == exp, {tag, " R3 streamed word"}, w, exp);
    end
    cs_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sdo_en == 1'b0, "R10 reset output off", sdo_en, 0);
    cs_on();
    tick(1'b0);
    check(sdo_en == 1'b0, "R1 zero before start keeps output off", sdo_en, 0);
    cs_off();

    // R7: latch closed at reset
    do_write(3'd2, 16'h1234, 0);
    do_erase(3'd5);
    read_seq(3'd0, DEPTH, "R7 reset content intact, R4 reset ones");

    // R11: don't-care low bit set
    do_ext(2'b11, 1'b1);

    // R1 R4: sweep every address, varying leading zeros
    for (int a = 0; a < DEPTH; a++)
      do_write(AW'(a), WW'(a * 16'h1357) ^ 16'hA5C3, a % 3);
    for (int a = 0; a < DEPTH; a++) read_seq(AW'(a), 1, "R1 R4 sweep");
    read_seq(3'd5, DEPTH + 3, "R3 wrap");

    // R5 + R9: erase, clock a start pattern during busy
    cs_on();
    send_cmd(2'b11, 3'd6);
    tick(1'b1);
    tick(1'b1);
    tick(1'b0);
    begin
      int n = 0;
      while (!(sdo_en && sdo) && n < 5000) begin
        @(negedge clk);
        n++;
      end
    end
    repeat (2) @(negedge clk);
    check({sdo_en, sdo} == 2'b11, "R9 start bit during busy ignored", {sdo_en, sdo}, 2'b11);
    tick(1'b0);
    repeat (2 * H) @(negedge clk);
    check({sdo_en, sdo} == 2'b11, "R8 ready held through clocking", {sdo_en, sdo}, 2'b11);
    tick(1'b1);
    repeat (2 * H) @(negedge clk);
    check(sdo_en == 1'b0, "R8 start bit clears status", sdo_en, 0);
    cs_off();
    mdl[6] = '1;
    read_seq(3'd6, 1, "R5 erased word");
    do_erase(3'd1);
    read_seq(3'd0, DEPTH, "R5 single erase");

    // R10: abort mid data
    cs_on();
    send_cmd(2'b01, 3'd4);
    for (int i = 0; i < 5; i++) tick(1'b0);
    cs_off();
    check(sdo_en == 1'b0, "R10 output off after deselect", sdo_en, 0);
    read_seq(3'd4, 1, "R10 aborted write no effect");

    // R6 fill-all, R11 don't-care bit
    do_wral(16'h3C5A, 1'b1);
    read_seq(3'd2, DEPTH, "R6 fill-all");
    do_wral(16'h0F00, 1'b0);
    read_seq(3'd0, DEPTH, "R6 fill over old data");

    // R5 wipe-all
    do_eral(1'b1);
    read_seq(3'd7, DEPTH, "R5 wipe-all");

    // R7: close latch, then modifying commands must not change anything
    do_write(3'd3, 16'h00FF, 0);
    do_ext(2'b00, 1'b1);
    do_write(3'd3, 16'h1111, 1);
    do_wral(16'h2222, 1'b0);
    do_erase(3'd3);
    read_seq(3'd0, DEPTH, "R7 locked array unchanged");

    finish_run();
  end

endmodule